// File: doc/BRIEF.md
# Bitplane Pixel Serializer

This block is the last stage of a planar video path. Sixteen-bit memory words arrive one at a time on a load strobe and collect in a four-slot staging buffer. At the end of every pixel group the block checks that buffer. If all four slots are filled, the words move into four plane shift registers and the buffer empties. The shift registers then emit one pixel index per clock. The way the planes combine depends on the display resolution. Each index selects an entry in a sixteen-entry palette of 9-bit RGB values, and that entry drives the colour output.

If no complete set of words is waiting at a group boundary, the shift registers have already shifted out to zero. The output then shows palette entry 0, which serves as the border colour. Words that reach a full buffer are discarded. Words in a partly filled buffer stay there until the buffer fills and is copied out at a later boundary.

Top module: `plane_shifter`

## Requirements
- R1: While `rst_n` is low, `pix_index`, `pix_rgb` and `pix_mono` are all zero.
- R2: Each cycle with `load` high stores `load_word` in the next free buffer slot. The first word stored becomes plane 0, the second plane 1, the third plane 2 and the fourth plane 3. A word presented while all four slots are full is dropped.
- R3: A transfer to the shift registers happens only at a group boundary and only when all four slots are full. The transfer empties the buffer. Words in a partly filled buffer are kept and complete a later transfer.
- R4: With `res` = 0 (low), the group is 16 cycles long. The index of pixel j (j = 0..15) has bit n equal to bit 15−j of plane n.
- R5: With `res` = 1 (medium), the group is 32 cycles long and index bits 3:2 are zero. Pixels 0..15 take bit 0 from plane 0 and bit 1 from plane 1. Pixels 16..31 take bit 0 from plane 2 and bit 1 from plane 3. In both halves the planes are read from bit 15 down to bit 0.
- R6: With `res` = 2 or 3 (high), the group is 64 cycles long and the index is one bit wide. The pixels come from planes 0, 1, 2 and 3 in turn, each read from bit 15 down to bit 0. `pix_mono` always equals bit 0 of `pix_index`.
- R7: When no transfer happened at the previous boundary, the index is 0 and `pix_rgb` shows palette entry 0.
- R8: The group phase counts from 0 in the first cycle after reset is released. Suppose four words are presented in cycles 0, 3, 6 and 9 in low resolution. Then the colour of their first pixel appears in cycle 18.
- R9: `pix_rgb` equals the palette entry selected by `pix_index`. A palette entry is written through `pal_we`, `pal_addr` and `pal_data`, and writes are accepted during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load | input | 1 | Word strobe |
| load_word | input | 16 | Video word to store |
| res | input | 2 | Resolution: 0 low, 1 medium, 2/3 high |
| pal_we | input | 1 | Palette write enable |
| pal_addr | input | 4 | Palette entry to write |
| pal_data | input | 9 | RGB value to write |
| pix_index | output | 4 | Current pixel colour index |
| pix_rgb | output | 9 | Palette colour of the current pixel |
| pix_mono | output | 1 | Monochrome pixel (index bit 0) |

## Verification
The low-resolution patterns are chosen so that the first group steps through all sixteen indices in descending order. That single group therefore covers the plane-to-bit mapping, every palette entry, and the exact cycle of the first pixel. Further groups test the buffer rules. A group that receives three words must give border colour, and the group after it, which adds only one word, must show those kept words. A group that receives five words must show only the first four. Medium and high resolution each get two distinct word sets, with an empty group in medium. These tell apart the plane pair order, the serial word order and a group length that is wrong for the mode.

// File: rtl/plane_shifter.sv
module plane_shifter #(
  parameter int WORD_W  = 16,
  parameter int COLOR_W = 9
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [WORD_W-1:0]  load_word,
  input  logic [1:0]         res,
  input  logic               pal_we,
  input  logic [3:0]         pal_addr,
  input  logic [COLOR_W-1:0] pal_data,
  output logic [3:0]         pix_index,
  output logic [COLOR_W-1:0] pix_rgb,
  output logic               pix_mono
);
  localparam int PLANES = 4;
  localparam int LW     = $clog2(WORD_W);
  localparam int PH_W   = LW + 2;

  logic [WORD_W-1:0]  stage [PLANES];
  logic [WORD_W-1:0]  sr    [PLANES];
  logic [COLOR_W-1:0] pal   [16];
  logic [2:0]         fill;
  logic [PH_W-1:0]    phase;
  logic               group_end, xfer;
  logic [3:0]         idx, idx_q;

  always_comb begin
    case (res)
      2'd0:    group_end = &phase[LW-1:0];
      2'd1:    group_end = &phase[LW:0];
      default: group_end = &phase;
    endcase
  end

  assign xfer = group_end && (fill == 3'(PLANES));

  always_ff @(posedge clk) begin
    if (!rst_n) phase <= '0;
    else        phase <= phase + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fill <= '0;
    end else if (xfer) begin
      fill <= {2'b00, load};
      if (load) stage[0] <= load_word;
    end else if (load && fill != 3'(PLANES)) begin
      stage[fill[1:0]] <= load_word;
      fill <= fill + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < PLANES; i++) sr[i] <= '0;
    end else if (xfer) begin
      for (int i = 0; i < PLANES; i++) sr[i] <= stage[i];
    end else begin
      case (res)
        2'd0: for (int i = 0; i < PLANES; i++) sr[i] <= sr[i] << 1;
        2'd1: begin
          sr[0] <= {sr[0][WORD_W-2:0], sr[2][WORD_W-1]};
          sr[1] <= {sr[1][WORD_W-2:0], sr[3][WORD_W-1]};
          sr[2] <= sr[2] << 1;
          sr[3] <= sr[3] << 1;
        end
        default: begin
          sr[0] <= {sr[0][WORD_W-2:0], sr[1][WORD_W-1]};
          sr[1] <= {sr[1][WORD_W-2:0], sr[2][WORD_W-1]};
          sr[2] <= {sr[2][WORD_W-2:0], sr[3][WORD_W-1]};
          sr[3] <= sr[3] << 1;
        end
      endcase
    end
  end

  always_comb begin
    case (res)
      2'd0:    idx = {sr[3][WORD_W-1], sr[2][WORD_W-1], sr[1][WORD_W-1], sr[0][WORD_W-1]};
      2'd1:    idx = {2'b00, sr[1][WORD_W-1], sr[0][WORD_W-1]};
      default: idx = {3'b000, sr[0][WORD_W-1]};
    endcase
  end

  always_ff @(posedge clk) begin
    if (pal_we) pal[pal_addr] <= pal_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q     <= '0;
      pix_index <= '0;
      pix_rgb   <= '0;
      pix_mono  <= 1'b0;
    end else begin
      idx_q     <= idx;
      pix_index <= idx_q;
      pix_rgb   <= pal[idx_q];
      pix_mono  <= idx_q[0];
    end
  end
endmodule

// File: rtl/plane_shifter_chk.sv
module plane_shifter_chk #(
  parameter int COLOR_W = 9
) (
  input logic               clk,
  input logic               rst_n,
  input logic               load,
  input logic [1:0]         res,
  input logic               pal_we,
  input logic [2:0]         fill,
  input logic               xfer,
  input logic [3:0]         pix_index,
  input logic [COLOR_W-1:0] pix_rgb,
  input logic [COLOR_W-1:0] pal [16]
);
  // R2
  fill_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= 3'd4);

  // R2
  fill_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !xfer && fill < 3'd4) |=> fill == $past(fill) + 3'd1);

  // R3
  empty_after_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer |=> fill <= 3'd1);

  // R9
  rgb_lookup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(pal_we)) |-> pix_rgb == pal[pix_index]);

  // R5
  med_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n, 2) && $past(res, 2) == 2'd1) |-> pix_index[3:2] == 2'b00);

  // R6
  high_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n, 2) && $past(res, 2) >= 2'd2) |-> pix_index[3:1] == 3'b000);
endmodule

bind plane_shifter plane_shifter_chk #(.COLOR_W(COLOR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .load(load), .res(res), .pal_we(pal_we),
  .fill(fill), .xfer(xfer), .pix_index(pix_index), .pix_rgb(pix_rgb), .pal(pal)
);

// File: tb/plane_shifter_tb.sv
module plane_shifter_tb;
  typedef struct { logic [3:0] idx; string req; } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load = 1'b0;
  logic [15:0] load_word = '0;
  logic [1:0]  res = 2'd0;
  logic        pal_we = 1'b0;
  logic [3:0]  pal_addr = '0;
  logic [8:0]  pal_data = '0;
  logic [3:0]  pix_index;
  logic [8:0]  pix_rgb;
  logic        pix_mono;

  plane_shifter u_dut (.clk(clk), .rst_n(rst_n), .load(load), .load_word(load_word),
    .res(res), .pal_we(pal_we), .pal_addr(pal_addr), .pal_data(pal_data),
    .pix_index(pix_index), .pix_rgb(pix_rgb), .pix_mono(pix_mono));

  always #10 clk = ~clk;

  exp_t        q[$];
  logic [15:0] mb[$];
  logic [15:0] sch[int];
  logic [8:0]  pal_m [16];
  int          md, gl;
  int          n_chk = 0, n_bad = 0;
  bit          mon_en = 1'b0, done = 1'b0;
  int          mon_cnt = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (mon_en) begin
      #4;
      mon_cnt++;
      if (mon_cnt >= 2 && q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        check(pix_index == e.idx && pix_rgb == pal_m[e.idx] && pix_mono == e.idx[0],
              e.req, {pix_mono, pix_rgb, pix_index}, {e.idx[0], pal_m[e.idx], e.idx});
      end
    end
  end

  task automatic push_zero(input string r);
    for (int j = 0; j < gl; j++) q.push_back('{4'd0, r});
  endtask

  task automatic add_group(input int k, input int n, input logic [15:0] w[5], input string r);
    for (int i = 0; i < n; i++) begin
      sch[k*gl + 3*i] = w[i];
      if (mb.size() < 4) mb.push_back(w[i]);
    end
    if (mb.size() == 4) begin
      for (int j = 0; j < gl; j++) begin
        logic [3:0] v;
        int b;
        b = 15 - (j % 16);
        if (md == 0)      v = {mb[3][b], mb[2][b], mb[1][b], mb[0][b]};
        else if (md == 1) v = {2'b00, mb[2*(j/16)+1][b], mb[2*(j/16)][b]};
        else              v = {3'b000, mb[j/16][b]};
        q.push_back('{v, r});
      end
      mb.delete();
    end else begin
      push_zero("R7");
    end
  endtask

  task automatic begin_test(input int mode);
    md = mode;
    gl = (mode == 0) ? 16 : (mode == 1) ? 32 : 64;
    res = 2'(mode);
    q.delete(); mb.delete(); sch.delete();
    push_zero("R7");
  endtask

  task automatic run(input int ngroups);
    rst_n = 1'b0;
    load = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(pix_index == 0 && pix_rgb == 0 && !pix_mono, "R1", {pix_mono, pix_rgb, pix_index}, 0);
    rst_n = 1'b1;
    mon_cnt = 0;
    mon_en = 1'b1;
    for (int c = 0; c < (ngroups + 1) * gl + 4; c++) begin
      load = sch.exists(c);
      load_word = sch.exists(c) ? sch[c] : 16'h0;
      if (md == 0 && c == 17) check(pix_rgb == pal_m[0], "R8", pix_rgb, pal_m[0]);
      if (md == 0 && c == 18) check(pix_rgb == pal_m[15], "R8", pix_rgb, pal_m[15]);
      @(negedge clk);
    end
    load = 1'b0;
    while (q.size() > 0) @(negedge clk);
    mon_en = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < 16; i++) pal_m[i] = 9'((i * 53 + 7) % 512);
    @(negedge clk);
    for (int i = 0; i < 16; i++) begin
      pal_we = 1'b1; pal_addr = 4'(i); pal_data = pal_m[i];
      @(negedge clk);
    end
    pal_we = 1'b0;

    // R4 low: all indices, R3 kept words, R2 overflow dropped, R9 lookups
    begin_test(0);
    add_group(0, 4, '{16'hAAAA, 16'hCCCC, 16'hF0F0, 16'hFF00, 16'h0}, "R4");
    add_group(1, 3, '{16'h1234, 16'h5678, 16'h9ABC, 16'h0, 16'h0}, "R3");
    add_group(2, 1, '{16'hDEF0, 16'h0, 16'h0, 16'h0, 16'h0}, "R3");
    add_group(3, 5, '{16'h0F0F, 16'h3C3C, 16'h6666, 16'h8181, 16'hFFFF}, "R2");
    run(4);

    // R5 medium, with an empty group between (R7)
    begin_test(1);
    add_group(0, 4, '{16'hC3A5, 16'h5A3C, 16'hFF00, 16'h0F0F, 16'h0}, "R5");
    add_group(1, 0, '{16'h0, 16'h0, 16'h0, 16'h0, 16'h0}, "R7");
    add_group(2, 4, '{16'h8001, 16'h7FFE, 16'h1357, 16'h2468, 16'h0}, "R5");
    run(3);

    // R6 high
    begin_test(2);
    add_group(0, 4, '{16'h8000, 16'h0001, 16'hF00F, 16'h1248, 16'h0}, "R6");
    add_group(1, 4, '{16'hFFFF, 16'h0000, 16'hAAAA, 16'h5555, 16'h0}, "R6");
    run(2);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule